// File: doc/BRIEF.md
# Video Controller CPU Register Interface

This block is the processor-facing register file of a tile-based video controller. The CPU reaches it through a window of eight byte registers that repeats every eight bytes across a larger address range. Two write-only registers hold the display configuration. A read-only status register reports frame events. The remaining ports give byte access to sprite-attribute memory, a two-write scroll register, a two-write video-memory address register and a video-memory data port.

Frame-timing logic outside the block supplies pulses for the start and end of vertical blanking, for a sprite-0 collision and for a sprite overflow. The block turns these pulses into status flags and drives an active-low interrupt request to the CPU.

The block stores no pixel data and does no rendering. The sprite-attribute memory and the video memory sit outside it. Only their address, write strobe and read data cross the boundary.

Top module: `vid_reg_top`

## Requirements
- R1: The register window starts at 0x2000 and covers 0x2000-0x3FFF. Address bits [2:0] select the register: 0 control A, 1 control B, 2 status, 3 sprite address, 4 sprite data, 5 scroll, 6 video address, 7 video data. The bits in between are ignored, so a register repeats every 8 bytes. Accesses outside the window change nothing.
- R2: Control A fields are: bit 7 interrupt enable, bit 5 tall (8x16) sprites, bit 4 background pattern base high, bit 3 sprite pattern base high, bit 2 step-by-32, bits 1-0 name-table select.
- R3: Control B fields are: bits 7-5 colour emphasis, bit 4 show sprites, bit 3 show background, bit 2 sprite left-column clip off, bit 1 background left-column clip off, bit 0 monochrome.
- R4: A status read returns {vblank, sprite-0 hit, overflow, 5'b0}, taken before any clear that the read causes. A read of a write-only register returns 0.
- R5: A status read clears the vblank flag and the shared first/second-write toggle after the read cycle.
- R6: A vblank-start pulse sets the vblank flag whatever the interrupt and display enables are. A vblank-end pulse clears it. When a vblank-start pulse and a status read fall in the same cycle, the flag ends up set.
- R7: Sprite-0 hit is set only when sprites and background are both shown. Overflow is set only when at least one of them is shown. Both flags clear on vblank end.
- R8: irqN is low exactly while the vblank flag and interrupt enable are both 1. Enabling the interrupt during vblank drives irqN low in the next cycle.
- R9: A write to the sprite address register loads it. Each sprite data write pulses oamWe and then advances the address by 1, wrapping at 8 bits. Sprite data reads return oamRdata and leave the address unchanged.
- R10: Scroll writes load scrollX when the toggle is clear and scrollY when it is set. Each scroll write flips the toggle.
- R11: With the toggle clear, a video-address write loads address bits [13:8] from data bits [5:0]. With the toggle set, it loads bits [7:0]. Each write flips the toggle, which is shared with the scroll register.
- R12: Each video data access advances vaddr by 1, or by 32 when step-by-32 is set, wrapping at 14 bits. A write pulses vramWe and a read returns vramRdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuRd | input | 1 | CPU read strobe |
| cpuWr | input | 1 | CPU write strobe |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data (0 when not reading in window) |
| vblankStart | input | 1 | Start-of-vblank pulse |
| vblankEnd | input | 1 | End-of-vblank pulse |
| spr0HitEvt | input | 1 | Sprite-0 collision pulse |
| sprOvfEvt | input | 1 | Sprite overflow pulse |
| irqN | output | 1 | Active-low vblank interrupt |
| ntSel | output | 2 | Name-table select |
| stepWide | output | 1 | Data-port step of 32 |
| sprPatHigh | output | 1 | Sprite pattern base high |
| bgPatHigh | output | 1 | Background pattern base high |
| sprTall | output | 1 | 8x16 sprites |
| emphasis | output | 3 | Colour emphasis |
| sprShow | output | 1 | Show sprites |
| bgShow | output | 1 | Show background |
| sprClipOff | output | 1 | Sprites visible in left column |
| bgClipOff | output | 1 | Background visible in left column |
| mono | output | 1 | Monochrome |
| oamAddr | output | 8 | Sprite memory address |
| oamWe | output | 1 | Sprite memory write strobe |
| oamWdata | output | 8 | Sprite memory write data |
| oamRdata | input | 8 | Sprite memory read data |
| scrollX | output | 8 | Horizontal scroll |
| scrollY | output | 8 | Vertical scroll |
| vaddr | output | 14 | Video memory address |
| vramWe | output | 1 | Video memory write strobe |
| vramRe | output | 1 | Video memory read strobe |
| vramWdata | output | 8 | Video memory write data |
| vramRdata | input | 8 | Video memory read data |

## Verification
The bench reads status twice in a row to expose the read side effect. A design that cleared the flags before the read would return zero on the first read, and one that never cleared them would return the flag again on the second. It interleaves scroll and address writes, and follows them with a status read. A design that kept a separate toggle per register, or that ignored the read reset, would load the wrong byte. The remaining cases are these: overflow and hit pulses under partial display enables; a vblank-start pulse arriving in the same cycle as a status read; 14-bit wrap with the 32 step; and an 8-bit sprite address wrap. Each of these catches a wrong gate, a wrong priority or a wrong width.

// File: rtl/vid_reg_pkg.sv
package vid_reg_pkg;

  localparam int NUM_REGS = 8;

  typedef enum logic [2:0] {
    REG_CTRL_A   = 3'd0,
    REG_CTRL_B   = 3'd1,
    REG_STATUS   = 3'd2,
    REG_OAM_ADDR = 3'd3,
    REG_OAM_DATA = 3'd4,
    REG_SCROLL   = 3'd5,
    REG_VADDR    = 3'd6,
    REG_VDATA    = 3'd7
  } regSel_e;

  // Strobes from decode/control to the datapath
  typedef struct packed {
    logic wrCtrlA;
    logic wrCtrlB;
    logic rdStatus;
    logic wrOamAddr;
    logic wrOamData;
    logic rdOamData;
    logic wrScroll;
    logic wrVaddr;
    logic wrVdata;
    logic rdVdata;
    logic secondWr;
  } regStrobe_t;

endpackage

// File: rtl/vid_reg_ctrl.sv
module vid_reg_ctrl
  import vid_reg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int WIN_LOG2  = 13,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  output regStrobe_t        stb,
  output logic              inWindow,
  output logic              toggle
);

  localparam int SEL_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0] selVec;
  logic                rdEn;
  logic                unusedAddrBits;

  assign inWindow       = (cpuAddr[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
  assign unusedAddrBits = ^cpuAddr[WIN_LOG2-1:SEL_W];
  // write wins if both strobes appear
  assign rdEn           = cpuRd && !cpuWr;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gDecode
      assign selVec[g] = inWindow && (cpuAddr[SEL_W-1:0] == SEL_W'(g));
    end
  endgenerate

  always_comb begin
    stb           = '0;
    stb.wrCtrlA   = cpuWr && selVec[REG_CTRL_A];
    stb.wrCtrlB   = cpuWr && selVec[REG_CTRL_B];
    stb.rdStatus  = rdEn  && selVec[REG_STATUS];
    stb.wrOamAddr = cpuWr && selVec[REG_OAM_ADDR];
    stb.wrOamData = cpuWr && selVec[REG_OAM_DATA];
    stb.rdOamData = rdEn  && selVec[REG_OAM_DATA];
    stb.wrScroll  = cpuWr && selVec[REG_SCROLL];
    stb.wrVaddr   = cpuWr && selVec[REG_VADDR];
    stb.wrVdata   = cpuWr && selVec[REG_VDATA];
    stb.rdVdata   = rdEn  && selVec[REG_VDATA];
    stb.secondWr  = toggle;
  end

  // Shared first/second-write toggle
  always_ff @(posedge clk) begin
    if (!rstN)                         toggle <= 1'b0;
    else if (stb.wrScroll || stb.wrVaddr) toggle <= ~toggle;
    else if (stb.rdStatus)             toggle <= 1'b0;
  end

endmodule

// File: rtl/vid_reg_dp.sv
module vid_reg_dp
  import vid_reg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OAM_AW    = 8,
  parameter int VADDR_W   = 14,
  parameter int WIDE_STEP = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  logic               inWindow,
  input  logic               cpuRd,
  input  logic [2:0]         regSel,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  cpuRdata,
  input  logic               vblankStart,
  input  logic               vblankEnd,
  input  logic               spr0HitEvt,
  input  logic               sprOvfEvt,
  output logic               irqN,
  output logic [DATA_W-1:0]  ctrlA,
  output logic [DATA_W-1:0]  ctrlB,
  output logic [OAM_AW-1:0]  oamAddr,
  input  logic [DATA_W-1:0]  oamRdata,
  output logic [DATA_W-1:0]  scrollX,
  output logic [DATA_W-1:0]  scrollY,
  output logic [VADDR_W-1:0] vaddr,
  input  logic [DATA_W-1:0]  vramRdata,
  output logic               vbFlag,
  output logic               hitFlag,
  output logic               ovfFlag
);

  localparam int HI_W = VADDR_W - DATA_W;
  localparam logic [VADDR_W-1:0] STEP_ONE  = VADDR_W'(1);
  localparam logic [VADDR_W-1:0] STEP_WIDE = VADDR_W'(WIDE_STEP);

  logic showBg, showSpr, irqEn, wideStep;
  logic [VADDR_W-1:0] vStep;

  assign irqEn    = ctrlA[7];
  assign wideStep = ctrlA[2];
  assign showSpr  = ctrlB[4];
  assign showBg   = ctrlB[3];
  assign vStep    = wideStep ? STEP_WIDE : STEP_ONE;

  // Control registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlA <= '0;
      ctrlB <= '0;
    end else begin
      if (stb.wrCtrlA) ctrlA <= cpuWdata;
      if (stb.wrCtrlB) ctrlB <= cpuWdata;
    end
  end

  // Status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vbFlag  <= 1'b0;
      hitFlag <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (vblankStart)                      vbFlag <= 1'b1;
      else if (vblankEnd || stb.rdStatus)   vbFlag <= 1'b0;

      if (vblankEnd)                        hitFlag <= 1'b0;
      else if (spr0HitEvt && showBg && showSpr) hitFlag <= 1'b1;

      if (vblankEnd)                        ovfFlag <= 1'b0;
      else if (sprOvfEvt && (showBg || showSpr)) ovfFlag <= 1'b1;
    end
  end

  assign irqN = ~(vbFlag && irqEn);

  // Sprite memory address
  always_ff @(posedge clk) begin
    if (!rstN)              oamAddr <= '0;
    else if (stb.wrOamAddr) oamAddr <= cpuWdata[OAM_AW-1:0];
    else if (stb.wrOamData) oamAddr <= oamAddr + OAM_AW'(1);
  end

  // Scroll pair
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrollX <= '0;
      scrollY <= '0;
    end else if (stb.wrScroll) begin
      if (stb.secondWr) scrollY <= cpuWdata;
      else              scrollX <= cpuWdata;
    end
  end

  // Video memory address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddr <= '0;
    end else if (stb.wrVaddr) begin
      if (stb.secondWr) vaddr[DATA_W-1:0]       <= cpuWdata;
      else              vaddr[VADDR_W-1:DATA_W] <= cpuWdata[HI_W-1:0];
    end else if (stb.wrVdata || stb.rdVdata) begin
      vaddr <= vaddr + vStep;
    end
  end

  // Read mux
  always_comb begin
    cpuRdata = '0;
    if (cpuRd && inWindow) begin
      unique case (regSel)
        REG_STATUS:   cpuRdata = {vbFlag, hitFlag, ovfFlag, {(DATA_W-3){1'b0}}};
        REG_OAM_DATA: cpuRdata = oamRdata;
        REG_VDATA:    cpuRdata = vramRdata;
        default:      cpuRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/vid_reg_top.sv
module vid_reg_top
  import vid_reg_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int OAM_AW    = 8,
  parameter int VADDR_W   = 14,
  parameter int WIDE_STEP = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic               cpuRd,
  input  logic               cpuWr,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  cpuRdata,
  input  logic               vblankStart,
  input  logic               vblankEnd,
  input  logic               spr0HitEvt,
  input  logic               sprOvfEvt,
  output logic               irqN,
  output logic [1:0]         ntSel,
  output logic               stepWide,
  output logic               sprPatHigh,
  output logic               bgPatHigh,
  output logic               sprTall,
  output logic [2:0]         emphasis,
  output logic               sprShow,
  output logic               bgShow,
  output logic               sprClipOff,
  output logic               bgClipOff,
  output logic               mono,
  output logic [OAM_AW-1:0]  oamAddr,
  output logic               oamWe,
  output logic [DATA_W-1:0]  oamWdata,
  input  logic [DATA_W-1:0]  oamRdata,
  output logic [DATA_W-1:0]  scrollX,
  output logic [DATA_W-1:0]  scrollY,
  output logic [VADDR_W-1:0] vaddr,
  output logic               vramWe,
  output logic               vramRe,
  output logic [DATA_W-1:0]  vramWdata,
  input  logic [DATA_W-1:0]  vramRdata
);

  regStrobe_t        stb;
  logic              inWindow, toggle;
  logic              vbFlag, hitFlag, ovfFlag;
  logic [DATA_W-1:0] ctrlA, ctrlB;
  logic              unusedSlaveBit;

  vid_reg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .stb(stb), .inWindow(inWindow), .toggle(toggle)
  );

  vid_reg_dp #(.DATA_W(DATA_W), .OAM_AW(OAM_AW), .VADDR_W(VADDR_W), .WIDE_STEP(WIDE_STEP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inWindow(inWindow), .cpuRd(cpuRd),
    .regSel(cpuAddr[2:0]), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .vblankStart(vblankStart), .vblankEnd(vblankEnd),
    .spr0HitEvt(spr0HitEvt), .sprOvfEvt(sprOvfEvt), .irqN(irqN),
    .ctrlA(ctrlA), .ctrlB(ctrlB), .oamAddr(oamAddr), .oamRdata(oamRdata),
    .scrollX(scrollX), .scrollY(scrollY), .vaddr(vaddr), .vramRdata(vramRdata),
    .vbFlag(vbFlag), .hitFlag(hitFlag), .ovfFlag(ovfFlag)
  );

  assign unusedSlaveBit = ctrlA[6];
  assign ntSel      = ctrlA[1:0];
  assign stepWide   = ctrlA[2];
  assign sprPatHigh = ctrlA[3];
  assign bgPatHigh  = ctrlA[4];
  assign sprTall    = ctrlA[5];
  assign emphasis   = ctrlB[7:5];
  assign sprShow    = ctrlB[4];
  assign bgShow     = ctrlB[3];
  assign sprClipOff = ctrlB[2];
  assign bgClipOff  = ctrlB[1];
  assign mono       = ctrlB[0];
  assign oamWe      = stb.wrOamData;
  assign oamWdata   = cpuWdata;
  assign vramWe     = stb.wrVdata;
  assign vramRe     = stb.rdVdata;
  assign vramWdata  = cpuWdata;

endmodule

// File: rtl/vid_reg_chk.sv
module vid_reg_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] cpuAddr,
  input logic        cpuRd,
  input logic        cpuWr,
  input logic        vblankStart,
  input logic        vblankEnd,
  input logic        bgShow,
  input logic        sprShow,
  input logic [7:0]  oamAddr,
  input logic        oamWe,
  input logic [13:0] vaddr,
  input logic        vramWe,
  input logic        vramRe,
  input logic        stepWide,
  input logic [7:0]  scrollX,
  input logic        vbFlag,
  input logic        hitFlag,
  input logic        toggle
);

  logic inWin, statusRd, oamDataRd;
  assign inWin     = (cpuAddr[15:13] == 3'b001);
  assign statusRd  = cpuRd && !cpuWr && inWin && (cpuAddr[2:0] == 3'd2);
  assign oamDataRd = cpuRd && !cpuWr && inWin && (cpuAddr[2:0] == 3'd4);

  p_outside_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && !inWin) |=> ($stable(scrollX) && $stable(oamAddr) && $stable(vaddr)));

  p_status_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !vblankStart) |=> (!vbFlag && !toggle));

  p_vblank_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    vblankStart |=> vbFlag);

  p_vblank_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vblankEnd && !vblankStart) |=> !vbFlag);

  p_hit_gate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!hitFlag && !(bgShow && sprShow)) |=> !hitFlag);

  p_oam_read_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    oamDataRd |=> $stable(oamAddr));

  p_oam_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    oamWe |=> (oamAddr == $past(oamAddr) + 8'd1));

  p_vram_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    (vramWe || vramRe) |=> (vaddr == $past(vaddr) + ($past(stepWide) ? 14'd32 : 14'd1)));

endmodule

bind vid_reg_top vid_reg_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
  .vblankStart(vblankStart), .vblankEnd(vblankEnd), .bgShow(bgShow), .sprShow(sprShow),
  .oamAddr(oamAddr), .oamWe(oamWe), .vaddr(vaddr), .vramWe(vramWe), .vramRe(vramRe),
  .stepWide(stepWide), .scrollX(scrollX), .vbFlag(vbFlag), .hitFlag(hitFlag),
  .toggle(toggle)
);

// File: tb/sim_vid_reg_top.sv
module sim_vid_reg_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic cpuRd = 1'b0, cpuWr = 1'b0;
  logic [7:0] cpuWdata = '0;
  logic [7:0] cpuRdata;
  logic vblankStart = 1'b0, vblankEnd = 1'b0, spr0HitEvt = 1'b0, sprOvfEvt = 1'b0;
  logic irqN;
  logic [1:0] ntSel;
  logic stepWide, sprPatHigh, bgPatHigh, sprTall;
  logic [2:0] emphasis;
  logic sprShow, bgShow, sprClipOff, bgClipOff, mono;
  logic [7:0] oamAddr, oamWdata, oamRdata, scrollX, scrollY, vramWdata, vramRdata;
  logic oamWe, vramWe, vramRe;
  logic [13:0] vaddr;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory models on the far side of the ports
  assign oamRdata  = oamAddr ^ 8'h5A;
  assign vramRdata = vaddr[7:0] ^ 8'hC3;

  vid_reg_top u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .vblankStart(vblankStart),
    .vblankEnd(vblankEnd), .spr0HitEvt(spr0HitEvt), .sprOvfEvt(sprOvfEvt),
    .irqN(irqN), .ntSel(ntSel), .stepWide(stepWide), .sprPatHigh(sprPatHigh),
    .bgPatHigh(bgPatHigh), .sprTall(sprTall), .emphasis(emphasis),
    .sprShow(sprShow), .bgShow(bgShow), .sprClipOff(sprClipOff),
    .bgClipOff(bgClipOff), .mono(mono), .oamAddr(oamAddr), .oamWe(oamWe),
    .oamWdata(oamWdata), .oamRdata(oamRdata), .scrollX(scrollX),
    .scrollY(scrollY), .vaddr(vaddr), .vramWe(vramWe), .vramRe(vramRe),
    .vramWdata(vramWdata), .vramRdata(vramRdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data at each read cycle
  always @(negedge clk) begin
    if (cpuRd && expQ.size() > 0) begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      check(t, cpuRdata, e);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpuAddr = a; cpuWdata = d; cpuWr = 1'b1;
    @(posedge clk); #1;
    cpuWr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string tag, input bit withVbStart = 0);
    @(posedge clk); #1;
    cpuAddr = a; cpuRd = 1'b1; vblankStart = withVbStart;
    expQ.push_back(e); tagQ.push_back(tag);
    @(posedge clk); #1;
    cpuRd = 1'b0; vblankStart = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #1;
    case (which)
      0: vblankStart = 1'b1;
      1: vblankEnd   = 1'b1;
      2: spr0HitEvt  = 1'b1;
      default: sprOvfEvt = 1'b1;
    endcase
    @(posedge clk); #1;
    vblankStart = 1'b0; vblankEnd = 1'b0; spr0HitEvt = 1'b0; sprOvfEvt = 1'b0;
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state
    check("R8 reset irqN", irqN, 1);
    check("R10 reset scrollX", scrollX, 0);
    check("R11 reset vaddr", vaddr, 0);
    check("R9 reset oamAddr", oamAddr, 0);
    rd(16'h2002, 8'h00, "R4 reset status");
    rd(16'h2000, 8'h00, "R4 write-only reads 0");

    // R2 control A fields
    wr(16'h2000, 8'h3D);
    check("R2 sprTall", sprTall, 1);
    check("R2 bgPatHigh", bgPatHigh, 1);
    check("R2 sprPatHigh", sprPatHigh, 1);
    check("R2 stepWide", stepWide, 1);
    check("R2 ntSel", ntSel, 1);
    check("R2 irq off", irqN, 1);
    // R1 mirror and outside window
    wr(16'h3FF8, 8'h02);
    check("R1 mirror write", ntSel, 2);
    wr(16'h4000, 8'h03);
    check("R1 outside ignored", ntSel, 2);
    wr(16'h1FF8, 8'h01);
    check("R1 below window ignored", ntSel, 2);

    // R3 control B fields
    wr(16'h2001, 8'hB5);
    check("R3 emphasis", emphasis, 3'b101);
    check("R3 sprShow", sprShow, 1);
    check("R3 bgShow", bgShow, 0);
    check("R3 sprClipOff", sprClipOff, 1);
    check("R3 bgClipOff", bgClipOff, 0);
    check("R3 mono", mono, 1);

    // R7 gating
    pulse(2);
    pulse(3);
    rd(16'h2002, 8'h20, "R7 hit blocked, overflow with one layer");
    wr(16'h2009, 8'h18);
    pulse(2);
    rd(16'h2002, 8'h60, "R7 hit with both layers");
    wr(16'h2001, 8'h00);
    pulse(1);
    rd(16'h2002, 8'h00, "R7 cleared at vblank end");
    pulse(3);
    rd(16'h2002, 8'h00, "R7 overflow blocked when display off");

    // R6 / R5 / R8
    wr(16'h2000, 8'h00);
    pulse(0);
    check("R8 no irq when disabled", irqN, 1);
    rd(16'h2002, 8'h80, "R6 vblank set with display and irq off");
    rd(16'h2002, 8'h00, "R5 vblank cleared by read");
    pulse(0);
    wr(16'h2000, 8'h80);
    check("R8 enable during vblank", irqN, 0);
    pulse(1);
    check("R8 released at vblank end", irqN, 1);
    rd(16'h2002, 8'h00, "R6 vblank end clears");
    pulse(0);
    check("R8 irq at vblank start", irqN, 0);
    rd(16'h2002, 8'h80, "R4 read returns pre-clear value");
    check("R8 released after status read", irqN, 1);
    rd(16'h2002, 8'h00, "R6 collide read", 1'b1);
    rd(16'h2002, 8'h80, "R6 set wins over read");
    wr(16'h2000, 8'h00);

    // R10 scroll
    wr(16'h2005, 8'h12);
    wr(16'h2005, 8'h34);
    check("R10 scrollX", scrollX, 8'h12);
    check("R10 scrollY", scrollY, 8'h34);
    wr(16'h2005, 8'h56);
    rd(16'h2002, 8'h00, "R5 status during toggle");
    wr(16'h200D, 8'h78);
    check("R5 toggle reset by read", scrollX, 8'h78);
    check("R10 scrollY kept", scrollY, 8'h34);
    wr(16'h2005, 8'h9A);
    check("R10 second after reset", scrollY, 8'h9A);

    // R11 address, shared toggle
    wr(16'h2006, 8'hFF);
    wr(16'h2006, 8'h10);
    check("R11 two writes", vaddr, 14'h3F10);
    wr(16'h2005, 8'h01);
    wr(16'h2006, 8'h22);
    check("R11 shared toggle", vaddr, 14'h3F22);
    check("R11 scroll first", scrollX, 8'h01);
    rd(16'h2002, 8'h00, "R5 reset toggle");
    wr(16'h2006, 8'h21);
    wr(16'h2006, 8'h08);
    check("R11 after reset", vaddr, 14'h2108);

    // R12 data port
    wr(16'h2007, 8'hAA);
    check("R12 write step 1", vaddr, 14'h2109);
    rd(16'h2007, 8'h09 ^ 8'hC3, "R12 read data");
    check("R12 read step 1", vaddr, 14'h210A);
    wr(16'h2000, 8'h04);
    wr(16'h2007, 8'h55);
    check("R12 step 32", vaddr, 14'h212A);
    wr(16'h2006, 8'h3F);
    wr(16'h2006, 8'hF0);
    wr(16'h2007, 8'h00);
    check("R12 wrap 14 bits", vaddr, 14'h0010);

    // R9 sprite port
    wr(16'h2003, 8'hFE);
    check("R9 address load", oamAddr, 8'hFE);
    rd(16'h2004, 8'hFE ^ 8'h5A, "R9 data read");
    check("R9 read holds address", oamAddr, 8'hFE);
    wr(16'h2004, 8'h11);
    check("R9 write steps", oamAddr, 8'hFF);
    wr(16'h2004, 8'h22);
    check("R9 wrap", oamAddr, 8'h00);

    repeat (2) @(posedge clk);
    check("scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule